// File: doc/BRIEF.md
# Serial Scrambler with Ones-Run Guard

This block scrambles a serial transmit bit stream on its way from the character framer to the modulator. Each input bit arrives with a one-cycle strobe. For each strobe the block emits exactly one output bit, one cycle later. The output is the input bit XORed with two taps of a 17-stage history of earlier output bits. These are the bits output 14 and 17 strobes before. The feedback polynomial is 1 + x^-14 + x^-17, so a receiver that runs the inverse filter re-synchronizes by itself.

A steady run of ones at the input could still drive the line into a repeating pattern. To prevent this, a guard counter tracks consecutive input ones. Once 64 ones have been seen in a row, the next input bit is inverted before it is scrambled, and the counter starts again. A bypass input passes data through unchanged. The history register keeps shifting the output bit during bypass, so a receiver stays aligned when scrambling is switched on mid-stream.

Top module: `scr_guard_top`

## Requirements
- R1: After synchronous reset, `out_vld` and `out_bit` are 0, the history holds all zeros and the ones counter is 0.
- R2: Every cycle with `bit_vld` high yields `out_vld` high in the next cycle. A cycle without `bit_vld` yields `out_vld` low in the next cycle. `out_bit` changes only after a strobe.
- R3: With `bypass` low, the output bit equals the (possibly inverted) input bit XOR the output bit 14 strobes earlier XOR the output bit 17 strobes earlier. Outputs from before reset count as 0.
- R4: With `bypass` high, the output bit equals the input bit.
- R5: Each output bit is shifted into the history whether or not `bypass` is high.
- R6: With `bypass` low, once 64 consecutive input ones have been counted, the next strobed input bit is inverted before scrambling.
- R7: The ones counter returns to 0 on any strobed zero input and after it forces an inversion. A further inversion needs another 64 consecutive ones.
- R8: While `bypass` is high, the ones counter is held at 0 and no inversion happens.
- R9: A receiver-side inverse filter fed with the output recovers every scrambled input bit, except those the guard inverted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_vld | input | 1 | Strobe qualifying `bit_in` |
| bit_in | input | 1 | Serial data bit from the framer |
| bypass | input | 1 | 1 = pass data unscrambled |
| out_vld | output | 1 | Strobe qualifying `out_bit` |
| out_bit | output | 1 | Serial bit towards the modulator |

## Verification
The bench drives long runs of ones (200 in a row) and a run of 63 ones broken by a zero before a full 64. A design that counted off by one, or that failed to restart the count after an inversion, would invert the wrong bit or would flip the wrong number of bits. It switches from bypass back to scrambling mid-stream. A design that froze its history during bypass would then produce outputs the inverse filter cannot undo. It also inserts idle gaps between strobes, and checks that bypass clears a partly built run. This catches a design that shifted on idle cycles or carried a count across a bypassed bit.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int SCR_TAP_A     = 14;
  localparam int SCR_TAP_B     = 17;
  localparam int SCR_RUN_LIMIT = 64;

  function automatic logic scr_mix(input logic din, input logic flip,
                                   input logic fb);
    return din ^ flip ^ fb;
  endfunction
endpackage

// File: rtl/scr_ones_guard.sv
module scr_ones_guard #(
  parameter int RUN_LIMIT = 64,
  localparam int CNT_W = $clog2(RUN_LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  input  logic             bit_in,
  input  logic             clear,
  output logic             flip,
  output logic [CNT_W-1:0] run_cnt
);
  localparam logic [CNT_W-1:0] LIMIT = CNT_W'(RUN_LIMIT);

  assign flip = (run_cnt == LIMIT);

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      run_cnt <= '0;
    end else if (step) begin
      if (flip || !bit_in) run_cnt <= '0;
      else                 run_cnt <= run_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/scr_history.sv
module scr_history #(
  parameter int TAP_A = 14,
  parameter int TAP_B = 17,
  localparam int DEPTH = (TAP_A > TAP_B) ? TAP_A : TAP_B
) (
  input  logic clk,
  input  logic rst,
  input  logic shift,
  input  logic new_bit,
  output logic fb
);
  logic [DEPTH-1:0] hist;

  assign fb = hist[TAP_A-1] ^ hist[TAP_B-1];

  generate
    if (DEPTH == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst)        hist <= '0;
        else if (shift) hist <= new_bit;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst)        hist <= '0;
        else if (shift) hist <= {hist[DEPTH-2:0], new_bit};
      end
    end
  endgenerate
endmodule

// File: rtl/scr_guard_top.sv
module scr_guard_top
  import scr_pkg::*;
#(
  parameter int TAP_A     = SCR_TAP_A,
  parameter int TAP_B     = SCR_TAP_B,
  parameter int RUN_LIMIT = SCR_RUN_LIMIT,
  localparam int CNT_W    = $clog2(RUN_LIMIT + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_vld,
  input  logic bit_in,
  input  logic bypass,
  output logic out_vld,
  output logic out_bit
);
  logic             fb;
  logic             flip;
  logic             nxt_bit;
  logic [CNT_W-1:0] run_cnt;

  scr_ones_guard #(.RUN_LIMIT(RUN_LIMIT)) u_guard (
    .clk(clk), .rst(rst), .step(bit_vld), .bit_in(bit_in),
    .clear(bypass), .flip(flip), .run_cnt(run_cnt)
  );

  scr_history #(.TAP_A(TAP_A), .TAP_B(TAP_B)) u_hist (
    .clk(clk), .rst(rst), .shift(bit_vld), .new_bit(nxt_bit), .fb(fb)
  );

  always_comb begin
    if (bypass) nxt_bit = bit_in;
    else        nxt_bit = scr_mix(bit_in, flip, fb);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld <= 1'b0;
      out_bit <= 1'b0;
    end else begin
      out_vld <= bit_vld;
      if (bit_vld) out_bit <= nxt_bit;
    end
  end
endmodule

// File: rtl/scr_guard_chk.sv
module scr_guard_chk #(
  parameter int RUN_LIMIT = 64,
  parameter int CNT_W = 7
) (
  input logic             clk,
  input logic             rst,
  input logic             bit_vld,
  input logic             bit_in,
  input logic             bypass,
  input logic             out_vld,
  input logic             out_bit,
  input logic [CNT_W-1:0] run_cnt
);
  assert_vld_follow_R2: assert property (@(posedge clk) disable iff (rst)
    bit_vld |=> out_vld);
  assert_vld_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> !out_vld);
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !bit_vld |=> $stable(out_bit));
  assert_bypass_pass_R4: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bypass) |=> (out_bit == $past(bit_in)));
  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    run_cnt <= CNT_W'(RUN_LIMIT));
  assert_cnt_zero_R7: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && !bit_in) |=> (run_cnt == '0));
  assert_cnt_bypass_R8: assert property (@(posedge clk) disable iff (rst)
    bypass |=> (run_cnt == '0));
endmodule

bind scr_guard_top scr_guard_chk #(.RUN_LIMIT(RUN_LIMIT), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in), .bypass(bypass),
  .out_vld(out_vld), .out_bit(out_bit), .run_cnt(run_cnt)
);

// File: tb/scr_guard_top_tb.sv
module scr_guard_top_tb;
  logic clk = 1'b0, rst = 1'b1;
  logic bit_vld = 1'b0, bit_in = 1'b0, bypass = 1'b0;
  logic out_vld, out_bit;

  always #10 clk = ~clk;

  scr_guard_top u_dut (
    .clk(clk), .rst(rst), .bit_vld(bit_vld), .bit_in(bit_in),
    .bypass(bypass), .out_vld(out_vld), .out_bit(out_bit)
  );

  typedef struct {
    logic  exp;
    logic  eff;
    logic  raw;
    logic  byp;
    string tag;
  } item_t;

  item_t    sb[$];
  int       checks = 0, errors = 0;
  logic [16:0] m_hist = '0;
  int       m_cnt = 0;
  logic [16:0] rx_hist = '0;
  int       flips_seen = 0;
  logic     last_out = 1'b0;
  logic     mon_on = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic b, input logic byp, input string tag);
    item_t it;
    logic inv, eff, exp;
    if (byp) begin
      inv = 1'b0; eff = b; exp = b; m_cnt = 0;
    end else begin
      inv = (m_cnt == 64);
      eff = b ^ inv;
      m_cnt = inv ? 0 : (b ? m_cnt + 1 : 0);
      exp = eff ^ m_hist[13] ^ m_hist[16];
    end
    m_hist = {m_hist[15:0], exp};
    it.exp = exp; it.eff = eff; it.raw = b; it.byp = byp; it.tag = tag;
    sb.push_back(it);
    bit_vld = 1'b1; bit_in = b; bypass = byp;
    @(negedge clk);
    bit_vld = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // monitor: pops expected items and runs a receiver-side inverse filter
  always @(negedge clk) begin
    if (mon_on) begin
      if (out_vld) begin
        if (sb.size() == 0) begin
          check(0, "R2 unexpected out_vld", 1, 0);
        end else begin
          item_t it;
          logic d;
          it = sb.pop_front();
          check(out_bit == it.exp, it.tag, out_bit, it.exp);
          d = out_bit ^ rx_hist[13] ^ rx_hist[16];
          if (!it.byp) begin
            check(d == it.eff, "R9 descrambled", d, it.eff);
            if (d != it.raw) flips_seen++;
          end
          rx_hist = {rx_hist[15:0], out_bit};
        end
      end else begin
        check(out_bit == last_out, "R2 hold when idle", out_bit, last_out);
      end
      last_out = out_bit;
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int base;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(out_vld == 1'b0, "R1 reset out_vld", out_vld, 0);
    check(out_bit == 1'b0, "R1 reset out_bit", out_bit, 0);
    mon_on = 1'b1;

    // first bits after reset see a zero history (R1, R3)
    for (int i = 0; i < 20; i++) drive(i[0] ^ i[2], 1'b0, "R1 R3 start history");
    // random data with idle gaps (R2, R3)
    for (int i = 0; i < 60; i++) begin
      drive(1'($urandom), 1'b0, "R3 scramble");
      if (($urandom % 3) == 0) idle(1 + ($urandom % 3));
    end
    idle(2);

    // long ones run: flips at indices 64, 129, 194 (R6, R7)
    base = flips_seen;
    for (int i = 0; i < 200; i++) drive(1'b1, 1'b0, "R6 ones run");
    idle(2);
    check(flips_seen - base == 3, "R6 R7 flips in 200 ones", flips_seen - base, 3);

    // 63 ones, a zero, then 64 ones and one more (R7): exactly one flip
    drive(1'b0, 1'b0, "R7 clear");
    base = flips_seen;
    for (int i = 0; i < 63; i++) drive(1'b1, 1'b0, "R7 short run");
    drive(1'b0, 1'b0, "R7 zero breaks run");
    for (int i = 0; i < 65; i++) drive(1'b1, 1'b0, "R7 full run");
    idle(2);
    check(flips_seen - base == 1, "R7 flips after broken run", flips_seen - base, 1);

    // bypass random and long ones: no flip (R4, R8)
    for (int i = 0; i < 30; i++) drive(1'($urandom), 1'b1, "R4 bypass");
    for (int i = 0; i < 100; i++) drive(1'b1, 1'b1, "R8 bypass ones");
    // back to scrambling mid-stream, history kept current (R5)
    for (int i = 0; i < 40; i++) drive(1'($urandom), 1'b0, "R5 resume");

    // a bypassed bit clears a partial run (R8)
    drive(1'b0, 1'b0, "R8 clear");
    base = flips_seen;
    for (int i = 0; i < 50; i++) drive(1'b1, 1'b0, "R8 partial run");
    drive(1'b1, 1'b1, "R8 bypass one bit");
    for (int i = 0; i < 30; i++) drive(1'b1, 1'b0, "R8 after bypass");
    idle(3);
    check(flips_seen - base == 0, "R8 no flip across bypass", flips_seen - base, 0);
    check(sb.size() == 0, "R2 all items produced", sb.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule